// File: doc/BRIEF.md
# Periodic Tick Tap Timer

This block turns a shared, free-running 15-bit prescaler count into a periodic interrupt and a periodic event pulse. It keeps no counter of its own. It registers the previous prescaler value, finds which bits rose, and picks one of them according to a period code. The interrupt period and the event period each have their own code, so the two rates are set independently.

Software reaches the block through a small byte-wide register port. The port holds a control register with an enable bit and the interrupt period code, an interrupt-enable register, a sticky flag register, and an event-period register. The flag is cleared by writing a one to it. The interrupt request is the flag gated by the enable, and the block's only link to any wake-up logic is that line. The enable bit here is separate from any enable of the main counter that shares the prescaler.

Top module: `ptick_tap`

## Requirements
- R1: After reset every register reads 0 at all four addresses, and `irq` and `evtPulse` are low.
- R2: Address 0 holds the run bit in bit 0 and the interrupt period code in bits 6:3. Bits 7, 2 and 1 are not stored and read back as 0.
- R3: With run set and code k in 1..14, the flag (address 2, bit 0) is set when prescaler bit k rises. This gives one set per 2^(k+1) prescaler counts. The flag shows on the clock edge that samples the prescaler value where the bit rose, and it stays set until it is cleared.
- R4: Code 0 (off) and code 15 (reserved) never set the flag.
- R5: With the run bit clear, the block sets no flag and emits no event pulse.
- R6: Writing 1 to bit 0 of address 2 clears the flag. Writing 0 there leaves it unchanged.
- R7: `irq` is high exactly when the flag is set and bit 0 of the interrupt-enable register (address 1) is set.
- R8: Address 3 bits 3:0 hold the event period code. Codes 5..12 (64..8192 counts) give a one-cycle `evtPulse` when prescaler bit `code` rises, with the same timing as the flag. Every other code gives no pulse. The event code is independent of the interrupt code and of the interrupt enable.
- R9: A change of interrupt code causes no flag set unless the newly selected bit truly rises from one prescaler sample to the next. A bit that is already high when it becomes selected does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preCount | input | 15 | Shared prescaler count |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 interrupt enable, 2 flag, 3 event code) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| irq | output | 1 | Periodic interrupt request |
| evtPulse | output | 1 | One-cycle periodic event pulse |

## Verification
A rise in `preCount` reaches the flag and `evtPulse` one clock edge after the value is presented. A register write takes effect at the edge where the strobe is sampled. `regRdata` and `irq` follow the stored state with no further delay. The bench changes inputs only on the falling edge and reads outputs at the next falling edge, or 1 ns after driving for combinational reads. For R3 it also checks that the flag is still low in the cycle the rise is presented.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
  localparam int PRE_W  = 15;  // shared prescaler width
  localparam int CODE_W = 4;   // period code width
  localparam int REG_W  = 8;   // register data width
  localparam int ADDR_W = 2;   // register address width
  localparam int CODE_LSB = 3; // interrupt code position in control register

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(3);

  // configuration strobes from control to datapath
  typedef struct packed {
    logic              run;
    logic [CODE_W-1:0] intCode;
    logic [CODE_W-1:0] evtCode;
  } tapCfg_t;
endpackage

// File: rtl/ptick_dp.sv
module ptick_dp
  import ptick_pkg::*;
#(
  parameter int EVT_LO = 5,
  parameter int EVT_HI = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  tapCfg_t          cfg,
  input  logic [PRE_W-1:0] preCount,
  output logic             intTick,
  output logic             evtPulse
);
  logic [PRE_W-1:0] prevCount;
  logic [PRE_W-1:0] rising;
  logic [PRE_W-1:0] intHit;
  logic [PRE_W-1:0] evtHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCount <= '0;
    else       prevCount <= preCount;
  end

  // every bit compared against its own history, so the code may change freely
  assign rising = preCount & ~prevCount;

  for (genvar k = 0; k < PRE_W; k++) begin : g_tap
    assign intHit[k] = rising[k] && (cfg.intCode == CODE_W'(k));
    if (k >= EVT_LO && k <= EVT_HI) begin : g_evt
      assign evtHit[k] = rising[k] && (cfg.evtCode == CODE_W'(k));
    end else begin : g_noevt
      assign evtHit[k] = 1'b0;
    end
  end

  assign intTick = cfg.run && (cfg.intCode != '0) && (|intHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPulse <= 1'b0;
    else       evtPulse <= cfg.run && (|evtHit);
  end

  // legal event periods are at least 64 counts, so pulses never abut
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);
  a_r5_no_tick_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run |=> !evtPulse);
endmodule

// File: rtl/ptick_regs.sv
module ptick_regs
  import ptick_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              intTick,
  output tapCfg_t           cfg,
  output logic [REG_W-1:0]  regRdata,
  output logic              irq
);
  logic              runReg;
  logic [CODE_W-1:0] intCodeReg;
  logic [CODE_W-1:0] evtCodeReg;
  logic              ieReg;
  logic              flagReg;
  logic              clrFlag;
  logic              unusedWdata;

  assign clrFlag = regWrite && (regAddr == A_FLAG) && regWdata[0];
  assign unusedWdata = ^{regWdata[REG_W-1], regWdata[CODE_LSB-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg     <= 1'b0;
      intCodeReg <= '0;
      evtCodeReg <= '0;
      ieReg      <= 1'b0;
    end else if (regWrite) begin
      case (regAddr)
        A_CTRL: begin
          runReg     <= regWdata[0];
          intCodeReg <= regWdata[CODE_LSB +: CODE_W];
        end
        A_IEN:   ieReg      <= regWdata[0];
        A_EVT:   evtCodeReg <= regWdata[CODE_W-1:0];
        default: ;
      endcase
    end
  end

  // a new tick wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagReg <= 1'b0;
    else if (intTick) flagReg <= 1'b1;
    else if (clrFlag) flagReg <= 1'b0;
  end

  assign cfg.run     = runReg;
  assign cfg.intCode = intCodeReg;
  assign cfg.evtCode = evtCodeReg;
  assign irq         = flagReg && ieReg;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:  regRdata = {1'b0, intCodeReg, 2'b00, runReg};
      A_IEN:   regRdata[0] = ieReg;
      A_FLAG:  regRdata[0] = flagReg;
      A_EVT:   regRdata[CODE_W-1:0] = evtCodeReg;
      default: regRdata = '0;
    endcase
  end

  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    intTick |=> flagReg);
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag && !intTick) |=> !flagReg);
  a_r3_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!intTick && !clrFlag) |=> $stable(flagReg));
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (intCodeReg == '0 || int'(intCodeReg) >= PRE_W) |-> !intTick);
endmodule

// File: rtl/ptick_tap.sv
module ptick_tap
  import ptick_pkg::*;
#(
  parameter int EVT_LO = 5,
  parameter int EVT_HI = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  preCount,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              irq,
  output logic              evtPulse
);
  tapCfg_t cfg;
  logic    intTick;

  ptick_regs u_regs (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .intTick(intTick), .cfg(cfg),
    .regRdata(regRdata), .irq(irq)
  );

  ptick_dp #(.EVT_LO(EVT_LO), .EVT_HI(EVT_HI)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .preCount(preCount),
    .intTick(intTick), .evtPulse(evtPulse)
  );
endmodule

// File: tb/tb_ptick_tap.sv
module tb_ptick_tap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // table: run, interrupt code, event code, counts, expected flags, expected pulses
  localparam int V_RUN[NV]  = '{1, 1, 1, 1, 1, 1, 0, 1};
  localparam int V_INT[NV]  = '{1, 3, 12, 15, 7, 14, 1, 0};
  localparam int V_EVT[NV]  = '{5, 6, 12, 4, 13, 5, 5, 8};
  localparam int V_N[NV]    = '{256, 256, 5000, 256, 256, 17000, 256, 1024};
  localparam int V_EI[NV]   = '{64, 16, 1, 0, 1, 1, 0, 0};
  localparam int V_EE[NV]   = '{4, 2, 1, 0, 0, 266, 0, 2};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] preCount = '0;
  logic        regWrite = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        irq;
  logic        evtPulse;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  ptick_tap dut (
    .clk(clk), .rstN(rstN), .preCount(preCount), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irq(irq), .evtPulse(evtPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    regAddr = a; #1; v = int'(regRdata);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl(input int run, input int code);
    return {1'b0, 4'(code), 2'b00, 1'(run)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int nI;
    int nE;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check($sformatf("R1 reg %0d", a), v, 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 evtPulse", int'(evtPulse), 0);

    // R2 control layout and readback
    wr(2'd0, 8'h4B);
    rd(2'd0, v);
    check("R2 ctrl readback", v, 8'h49);

    // R3 timing: flag not in the cycle of the rise, set one edge later
    preCount = 15'd0;
    wr(2'd0, ctrl(1, 1));
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    preCount = 15'd1; step(1);
    check("R3 no flag on pre=1", int'(irq), 0);
    preCount = 15'd2; #1;
    check("R3 flag not yet", int'(irq), 0);
    step(1);
    check("R3 flag after rise", int'(irq), 1);
    // R6 writing 0 keeps flag, writing 1 clears
    wr(2'd2, 8'h00);
    rd(2'd2, v);
    check("R6 write 0 keeps flag", v, 1);
    wr(2'd2, 8'h01);
    rd(2'd2, v);
    check("R6 write 1 clears", v, 0);
    // R7 irq gated by enable
    wr(2'd1, 8'h00);
    preCount = 15'd0; step(1);
    preCount = 15'd2; step(1);
    rd(2'd2, v);
    check("R7 flag set while disabled", v, 1);
    check("R7 irq masked", int'(irq), 0);
    wr(2'd1, 8'h01);
    check("R7 irq unmasked", int'(irq), 1);
    wr(2'd2, 8'h01);

    // R9 code change onto an already-high bit gives no tick
    preCount = 15'd8; step(2);
    wr(2'd0, ctrl(1, 3));
    step(3);
    rd(2'd2, v);
    check("R9 no spurious flag on code change", v, 0);
    preCount = 15'd0; step(1);
    preCount = 15'd8; step(1);
    rd(2'd2, v);
    check("R9 real rise after change", v, 1);

    // table-driven runs over counting prescaler (R3 R4 R5 R8)
    for (int t = 0; t < NV; t++) begin
      preCount = '0;
      wr(2'd0, ctrl(V_RUN[t], V_INT[t]));
      wr(2'd1, 8'h01);
      wr(2'd3, 8'(V_EVT[t]));
      wr(2'd2, 8'h01);
      nI = 0; nE = 0;
      for (int i = 0; i < V_N[t] + 2; i++) begin
        if (evtPulse) nE++;
        regWrite = 1'b0;
        if (irq) begin
          nI++;
          regWrite = 1'b1; regAddr = 2'd2; regWdata = 8'h01;
        end
        preCount = (i < V_N[t]) ? 15'(i) : 15'(V_N[t] - 1);
        @(negedge clk);
      end
      regWrite = 1'b0;
      check($sformatf("R3 R4 R5 vec %0d flag count", t), nI, V_EI[t]);
      check($sformatf("R8 R5 vec %0d event count", t), nE, V_EE[t]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule